// File: doc/BRIEF.md
# Private Cache Line Coherence Controller

This block keeps the coherence state of every line in a small private cache, using four states: invalid, shared, exclusive and modified. A local load or store that the line's state allows completes on its own. Otherwise the block puts a read, a read-invalidate or an invalidate message on its outgoing message port. It then waits for the matching response and installs the line before it finishes the access.

At the same time the block answers snoop messages that other caches send. A read snoop that finds a held copy returns the line data and leaves the copy shared. A read-invalidate snoop returns the data and drops the copy. An invalidate snoop drops the copy and returns no data. A snoop that finds no copy is answered without data. The cache is indexed directly by line number, so a line is "present" exactly when its state is not invalid. The interconnect, memory, replacement and store buffering all sit outside the block. A probe port reads back the state of any line.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line reads back as invalid, and no message or completion is raised. The state codes on the probe port are 2'b00 invalid, 2'b01 shared, 2'b10 exclusive and 2'b11 modified.
- R2: A load to a line in any valid state sends no message. reqDone rises in the cycle after the request is sampled, and reqRdData then holds the line's data.
- R3: A store to an exclusive or modified line sends no message. It completes one cycle after sampling and leaves the line modified, holding the store data.
- R4: A load to an invalid line sends a message of kind 2'b01 (read) in the cycle after sampling. The fill installs the line as shared when rspShared is high and as exclusive when it is low, and reqRdData returns rspData.
- R5: A store to an invalid line sends a message of kind 2'b10 (read-invalidate). Its fill installs the line as modified, holding the store data.
- R6: A store to a shared line sends a message of kind 2'b11 (invalidate). After the acknowledging rspValid the line is modified and holds the store data.
- R7: A read snoop (kind 2'b01) that hits a valid line is answered one cycle later with snpHasData high and the line data, and the line ends shared.
- R8: A read-invalidate snoop (kind 2'b10) that hits a valid line is answered with the data, and the line ends invalid. An invalidate snoop (kind 2'b11) also leaves the line invalid, but returns no data.
- R9: A snoop that hits an invalid line is answered with snpHasData low, and the line stays invalid.
- R10: reqDone is a single-cycle pulse. A local request presented while snpValid is high is not accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Local access request, held until reqDone |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqLine | input | IDX_W | Line index of the access |
| reqData | input | DATA_W | Store data |
| reqDone | output | 1 | Access completion pulse |
| reqRdData | output | DATA_W | Load result, valid with reqDone |
| outValid | output | 1 | Outgoing message strobe |
| outKind | output | 2 | 01 read, 10 read-invalidate, 11 invalidate |
| outLine | output | IDX_W | Line of the outgoing message |
| snpValid | input | 1 | Incoming snoop strobe |
| snpKind | input | 2 | 01 read, 10 read-invalidate, 11 invalidate |
| snpLine | input | IDX_W | Snooped line |
| snpAckValid | output | 1 | Snoop answer strobe |
| snpHasData | output | 1 | Answer carries line data |
| snpAckData | output | DATA_W | Supplied line data |
| rspValid | input | 1 | Fill or acknowledge for the pending message |
| rspShared | input | 1 | Another cache reported a copy |
| rspData | input | DATA_W | Fill data |
| probeLine | input | IDX_W | Line to read back |
| probeState | output | 2 | State of probeLine |

## Verification
Every result of this block comes from a register, so it shows up one clock edge after the input that causes it. A hit raises reqDone after one edge. A miss raises outValid after one edge, and a snoop is answered after one edge. A response raises reqDone and sets the new state on the edge that samples it. The bench drives every input just after a falling edge and reads the outputs at the next falling edge, so each result is read in the cycle it is due. A peer instance answers the snoops, and the bench checks the state pair of both caches after each step of a load/store ping-pong on every line.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } lineState_e;

  typedef enum logic [1:0] {
    MK_NONE  = 2'b00,
    MK_READ  = 2'b01,
    MK_RDINV = 2'b10,
    MK_INV   = 2'b11
  } msgKind_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'b00,
    FS_WAIT = 2'b01,
    FS_DONE = 2'b10
  } ctrlFsm_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       lineWr;    // write state and data of reqLine
    lineState_e wrState;   // state to install
    logic       wrFromRsp; // data source: 1 = fill data, 0 = store data
    logic       rdCap;     // capture load result
    logic       rdFromRsp; // load result source: 1 = fill data, 0 = array
  } dpStrobe_t;

endpackage

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [IDX_W-1:0] reqLine,
  input  lineState_e       reqState,
  input  logic             snpValid,
  input  logic             rspValid,
  input  logic             rspShared,
  output dpStrobe_t        strobe,
  output logic             reqDone,
  output logic             outValid,
  output msgKind_e         outKind,
  output logic [IDX_W-1:0] outLine
);

  ctrlFsm_e fsm, fsmNext;
  msgKind_e pendKind;
  msgKind_e issueKind;
  logic     accept, rdHit, wrHit, issue, fill;

  always_comb begin
    accept = (fsm == FS_IDLE) && reqValid && !snpValid;
    rdHit  = accept && !reqWrite && (reqState != LS_INV);
    wrHit  = accept && reqWrite && ((reqState == LS_EXC) || (reqState == LS_MOD));
    issue  = accept && !rdHit && !wrHit;
    if (!reqWrite)                 issueKind = MK_READ;
    else if (reqState == LS_SHR)   issueKind = MK_INV;
    else                           issueKind = MK_RDINV;
    fill   = (fsm == FS_WAIT) && rspValid;

    strobe = '0;
    if (rdHit) begin
      strobe.rdCap = 1'b1;
    end
    if (wrHit) begin
      strobe.lineWr  = 1'b1;
      strobe.wrState = LS_MOD;
    end
    if (fill) begin
      strobe.lineWr    = 1'b1;
      strobe.wrState   = (pendKind == MK_READ) ? (rspShared ? LS_SHR : LS_EXC) : LS_MOD;
      strobe.wrFromRsp = (pendKind == MK_READ);
      strobe.rdCap     = (pendKind == MK_READ);
      strobe.rdFromRsp = 1'b1;
    end

    fsmNext = fsm;
    case (fsm)
      FS_IDLE: begin
        if (issue)               fsmNext = FS_WAIT;
        else if (rdHit || wrHit) fsmNext = FS_DONE;
      end
      FS_WAIT: if (fill) fsmNext = FS_DONE;
      FS_DONE: fsmNext = FS_IDLE;
      default: fsmNext = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsm      <= FS_IDLE;
      pendKind <= MK_NONE;
      outValid <= 1'b0;
      outKind  <= MK_NONE;
      outLine  <= '0;
      reqDone  <= 1'b0;
    end else begin
      fsm      <= fsmNext;
      outValid <= issue;
      outKind  <= issue ? issueKind : MK_NONE;
      if (issue) begin
        outLine  <= reqLine;
        pendKind <= issueKind;
      end
      reqDone  <= rdHit || wrHit || fill;
    end
  end

  // R10: completion is a one-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  // R10: a snoop in the same cycle holds the local request back
  p_snoop_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fsm == FS_IDLE && snpValid) |=> (!outValid && !reqDone));

  // R3: a store hit on an owned line finishes without any message
  p_wr_hit_local_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fsm == FS_IDLE && reqValid && reqWrite && !snpValid &&
     (reqState == LS_EXC || reqState == LS_MOD)) |=> (reqDone && !outValid));

  // R4: a load miss raises a read message
  p_rd_miss_msg_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fsm == FS_IDLE && reqValid && !reqWrite && !snpValid && reqState == LS_INV)
      |=> (outValid && outKind == MK_READ && !reqDone));

endmodule

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  reqLine,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] rspData,
  output lineState_e        reqState,
  output logic [DATA_W-1:0] reqRdData,
  input  logic              snpValid,
  input  msgKind_e          snpKind,
  input  logic [IDX_W-1:0]  snpLine,
  output logic              snpAckValid,
  output logic              snpHasData,
  output logic [DATA_W-1:0] snpAckData,
  input  logic [IDX_W-1:0]  probeLine,
  output lineState_e        probeState
);

  lineState_e        stArr [LINES];
  logic [DATA_W-1:0] dArr  [LINES];

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    lineState_e        st;
    logic [DATA_W-1:0] d;
    logic              wrHere, snpHere;

    assign wrHere  = strobe.lineWr && (reqLine == IDX_W'(gi));
    assign snpHere = snpValid && (snpLine == IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st <= LS_INV;
        d  <= '0;
      end else if (wrHere) begin
        st <= strobe.wrState;
        d  <= strobe.wrFromRsp ? rspData : reqData;
      end else if (snpHere) begin
        case (snpKind)
          MK_READ:  if (st != LS_INV) st <= LS_SHR;
          MK_RDINV: st <= LS_INV;
          MK_INV:   st <= LS_INV;
          default:  st <= st;
        endcase
      end
    end

    assign stArr[gi] = st;
    assign dArr[gi]  = d;
  end

  assign reqState   = stArr[reqLine];
  assign probeState = stArr[probeLine];

  logic snpHit;
  assign snpHit = snpValid && (stArr[snpLine] != LS_INV) && (snpKind != MK_INV)
                  && (snpKind != MK_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snpAckValid <= 1'b0;
      snpHasData  <= 1'b0;
      snpAckData  <= '0;
      reqRdData   <= '0;
    end else begin
      snpAckValid <= snpValid;
      snpHasData  <= snpHit;
      snpAckData  <= snpHit ? dArr[snpLine] : '0;
      if (strobe.rdCap) reqRdData <= strobe.rdFromRsp ? rspData : dArr[reqLine];
    end
  end

  logic snpWrClash;
  assign snpWrClash = strobe.lineWr && (reqLine == snpLine);

  // R9: a snoop on an invalid line returns nothing and keeps it invalid
  p_snoop_miss_r9: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && stArr[snpLine] == LS_INV && !snpWrClash)
      |=> (snpAckValid && !snpHasData && stArr[$past(snpLine)] == LS_INV));

  // R7: a read snoop on a held line leaves it shared and supplies data
  p_read_share_r7: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpKind == MK_READ && stArr[snpLine] != LS_INV && !snpWrClash)
      |=> (snpHasData && stArr[$past(snpLine)] == LS_SHR));

  // R8: invalidating snoops always leave the line invalid
  p_inval_kill_r8: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && (snpKind == MK_RDINV || snpKind == MK_INV) && !snpWrClash)
      |=> (stArr[$past(snpLine)] == LS_INV));

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [IDX_W-1:0]  reqLine,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqDone,
  output logic [DATA_W-1:0] reqRdData,
  output logic              outValid,
  output logic [1:0]        outKind,
  output logic [IDX_W-1:0]  outLine,
  input  logic              snpValid,
  input  logic [1:0]        snpKind,
  input  logic [IDX_W-1:0]  snpLine,
  output logic              snpAckValid,
  output logic              snpHasData,
  output logic [DATA_W-1:0] snpAckData,
  input  logic              rspValid,
  input  logic              rspShared,
  input  logic [DATA_W-1:0] rspData,
  input  logic [IDX_W-1:0]  probeLine,
  output logic [1:0]        probeState
);

  dpStrobe_t  strobe;
  lineState_e reqState;
  lineState_e probeSt;
  msgKind_e   outKindE;

  coh_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqLine  (reqLine),
    .reqState (reqState),
    .snpValid (snpValid),
    .rspValid (rspValid),
    .rspShared(rspShared),
    .strobe   (strobe),
    .reqDone  (reqDone),
    .outValid (outValid),
    .outKind  (outKindE),
    .outLine  (outLine)
  );

  coh_datapath #(.LINES(LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqLine    (reqLine),
    .reqData    (reqData),
    .rspData    (rspData),
    .reqState   (reqState),
    .reqRdData  (reqRdData),
    .snpValid   (snpValid),
    .snpKind    (msgKind_e'(snpKind)),
    .snpLine    (snpLine),
    .snpAckValid(snpAckValid),
    .snpHasData (snpHasData),
    .snpAckData (snpAckData),
    .probeLine  (probeLine),
    .probeState (probeSt)
  );

  assign outKind    = outKindE;
  assign probeState = probeSt;

endmodule

// File: tb/tb_coh_line_ctrl.sv
module tb_coh_line_ctrl;

  localparam int LINES  = 4;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              reqValidV [2];
  logic              reqWriteV [2];
  logic [IDX_W-1:0]  reqLineV  [2];
  logic [DATA_W-1:0] reqDataV  [2];
  logic              reqDoneV  [2];
  logic [DATA_W-1:0] rdDataV   [2];
  logic              outValidV [2];
  logic [1:0]        outKindV  [2];
  logic [IDX_W-1:0]  outLineV  [2];
  logic              snpValidV [2];
  logic [1:0]        snpKindV  [2];
  logic [IDX_W-1:0]  snpLineV  [2];
  logic              ackValidV [2];
  logic              hasDataV  [2];
  logic [DATA_W-1:0] ackDataV  [2];
  logic              rspValidV [2];
  logic              rspSharedV[2];
  logic [DATA_W-1:0] rspDataV  [2];
  logic [IDX_W-1:0]  probeLineV[2];
  logic [1:0]        probeStV  [2];

  logic [DATA_W-1:0] mem [LINES];

  int total = 0;
  int bad   = 0;

  coh_line_ctrl #(.LINES(LINES), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValidV[0]), .reqWrite(reqWriteV[0]), .reqLine(reqLineV[0]),
    .reqData(reqDataV[0]), .reqDone(reqDoneV[0]), .reqRdData(rdDataV[0]),
    .outValid(outValidV[0]), .outKind(outKindV[0]), .outLine(outLineV[0]),
    .snpValid(snpValidV[0]), .snpKind(snpKindV[0]), .snpLine(snpLineV[0]),
    .snpAckValid(ackValidV[0]), .snpHasData(hasDataV[0]), .snpAckData(ackDataV[0]),
    .rspValid(rspValidV[0]), .rspShared(rspSharedV[0]), .rspData(rspDataV[0]),
    .probeLine(probeLineV[0]), .probeState(probeStV[0])
  );

  coh_line_ctrl #(.LINES(LINES), .DATA_W(DATA_W)) peer (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValidV[1]), .reqWrite(reqWriteV[1]), .reqLine(reqLineV[1]),
    .reqData(reqDataV[1]), .reqDone(reqDoneV[1]), .reqRdData(rdDataV[1]),
    .outValid(outValidV[1]), .outKind(outKindV[1]), .outLine(outLineV[1]),
    .snpValid(snpValidV[1]), .snpKind(snpKindV[1]), .snpLine(snpLineV[1]),
    .snpAckValid(ackValidV[1]), .snpHasData(hasDataV[1]), .snpAckData(ackDataV[1]),
    .rspValid(rspValidV[1]), .rspShared(rspSharedV[1]), .rspData(rspDataV[1]),
    .probeLine(probeLineV[1]), .probeState(probeStV[1])
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic probe(input int who, input int line, output int st);
    probeLineV[who] = IDX_W'(line);
    #1;
    st = int'(probeStV[who]);
  endtask

  task automatic checkPair(input string tag, input int line, input int expA, input int expB);
    int sa, sb;
    probe(0, line, sa);
    probe(1, line, sb);
    check({tag, " state dut"}, sa, expA);
    check({tag, " state peer"}, sb, expB);
  endtask

  // one access on instance who, with a message model that routes the
  // request as a snoop to the other instance and returns the response
  task automatic access(input int who, input bit wr, input int line,
                        input int wd, output int msg, output int rd);
    int  pe;
    int  phase;
    bit  finished;
    pe = 1 - who;
    phase = 0;
    finished = 1'b0;
    msg = 0;
    rd = 0;
    reqValidV[who] = 1'b1;
    reqWriteV[who] = wr;
    reqLineV[who]  = IDX_W'(line);
    reqDataV[who]  = DATA_W'(wd);
    for (int c = 0; c < 20 && !finished; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (reqDoneV[who]) begin
        rd = int'(rdDataV[who]);
        reqValidV[who] = 1'b0;
        rspValidV[who] = 1'b0;
        finished = 1'b1;
      end else if (phase == 0 && outValidV[who]) begin
        msg = int'(outKindV[who]);
        snpValidV[pe] = 1'b1;
        snpKindV[pe]  = outKindV[who];
        snpLineV[pe]  = outLineV[who];
        phase = 1;
      end else if (phase == 1) begin
        snpValidV[pe] = 1'b0;
        if (hasDataV[pe]) mem[line] = ackDataV[pe];
        rspValidV[who]  = 1'b1;
        rspSharedV[who] = hasDataV[pe];
        rspDataV[who]   = mem[line];
        phase = 2;
      end else if (phase == 2) begin
        rspValidV[who] = 1'b0;
      end
    end
    if (!finished) begin
      reqValidV[who] = 1'b0;
      rspValidV[who] = 1'b0;
      snpValidV[pe]  = 1'b0;
      check("R10 access completion", 0, 1);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int m, r, st, base;
    for (int w = 0; w < 2; w++) begin
      reqValidV[w] = 1'b0; reqWriteV[w] = 1'b0; reqLineV[w] = '0; reqDataV[w] = '0;
      snpValidV[w] = 1'b0; snpKindV[w] = 2'b00; snpLineV[w] = '0;
      rspValidV[w] = 1'b0; rspSharedV[w] = 1'b0; rspDataV[w] = '0;
      probeLineV[w] = '0;
    end
    for (int l = 0; l < LINES; l++) mem[l] = DATA_W'(l * 37 + 5);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int l = 0; l < LINES; l++) checkPair("R1 reset", l, 0, 0);
    check("R1 no message", int'(outValidV[0]), 0);
    check("R1 no done", int'(reqDoneV[0]), 0);

    for (int l = 0; l < LINES; l++) begin
      base = 256 * (l + 1);

      // R4 load miss, no other copy -> exclusive; R9 peer snooped while invalid
      access(0, 1'b0, l, 0, m, r);
      check("R4 read msg kind", m, 1);
      check("R4 fill data", r, l * 37 + 5);
      checkPair("R4/R9 exclusive fill", l, 2, 0);

      // R3 store hit on exclusive
      access(0, 1'b1, l, base + 1, m, r);
      check("R3 no message", m, 0);
      checkPair("R3 exclusive to modified", l, 3, 0);
      @(negedge clk);
      check("R10 done pulse", int'(reqDoneV[0]), 0);

      // R7 read snoop on modified -> shared, data supplied; R4 shared fill
      access(1, 1'b0, l, 0, m, r);
      check("R4 read msg kind", m, 1);
      check("R7 supplied data", r, base + 1);
      checkPair("R7/R4 shared pair", l, 1, 1);

      // R6 store to shared -> invalidate; R8 peer dropped
      access(0, 1'b1, l, base + 2, m, r);
      check("R6 invalidate kind", m, 3);
      checkPair("R6/R8 upgrade", l, 3, 0);

      access(1, 1'b0, l, 0, m, r);
      check("R7 supplied data", r, base + 2);
      checkPair("R7 shared pair", l, 1, 1);

      access(1, 1'b1, l, base + 3, m, r);
      check("R6 invalidate kind", m, 3);
      checkPair("R6/R8 peer upgrade", l, 0, 3);

      // R5 store miss -> read-invalidate; R8 modified peer supplies and drops
      access(0, 1'b1, l, base + 4, m, r);
      check("R5 rdinv kind", m, 2);
      checkPair("R5/R8 rdinv install", l, 3, 0);
      check("R8 peer data written back", int'(mem[l]), base + 3);

      // R2 load hit on modified
      access(0, 1'b0, l, 0, m, r);
      check("R2 no message", m, 0);
      check("R2 hit data", r, base + 4);
      checkPair("R2 state kept", l, 3, 0);

      access(1, 1'b0, l, 0, m, r);
      check("R7 supplied data", r, base + 4);
      checkPair("R7 shared pair", l, 1, 1);

      // R2 load hit on shared
      access(0, 1'b0, l, 0, m, r);
      check("R2 no message", m, 0);
      check("R2 shared hit data", r, base + 4);

      // R7 direct read snoop on a shared line
      snpValidV[0] = 1'b1; snpKindV[0] = 2'b01; snpLineV[0] = IDX_W'(l);
      @(negedge clk);
      snpValidV[0] = 1'b0;
      check("R7 ack valid", int'(ackValidV[0]), 1);
      check("R7 shared snoop has data", int'(hasDataV[0]), 1);
      check("R7 shared snoop data", int'(ackDataV[0]), base + 4);
      probe(0, l, st);
      check("R7 stays shared", st, 1);
    end

    // R10 request held off by a simultaneous snoop
    reqValidV[0] = 1'b1; reqWriteV[0] = 1'b1; reqLineV[0] = '0; reqDataV[0] = 16'h00AA;
    snpValidV[0] = 1'b1; snpKindV[0] = 2'b01; snpLineV[0] = IDX_W'(1);
    @(negedge clk);
    check("R10 stalled: no message", int'(outValidV[0]), 0);
    check("R10 stalled: no done", int'(reqDoneV[0]), 0);
    snpValidV[0] = 1'b0;
    reqValidV[0] = 1'b0;
    @(negedge clk);
    check("R10 withdrawn: no message", int'(outValidV[0]), 0);
    checkPair("R10 line untouched", 0, 1, 1);

    // R8 invalidate snoop: no data, line dropped
    snpValidV[0] = 1'b1; snpKindV[0] = 2'b11; snpLineV[0] = IDX_W'(2);
    @(negedge clk);
    snpValidV[0] = 1'b0;
    check("R8 invalidate no data", int'(hasDataV[0]), 0);
    probe(0, 2, st);
    check("R8 invalidated", st, 0);

    // R9 snoop on an invalid line
    snpValidV[0] = 1'b1; snpKindV[0] = 2'b10; snpLineV[0] = IDX_W'(2);
    @(negedge clk);
    snpValidV[0] = 1'b0;
    check("R9 ack valid", int'(ackValidV[0]), 1);
    check("R9 miss no data", int'(hasDataV[0]), 0);
    probe(0, 2, st);
    check("R9 stays invalid", st, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule